// File: doc/BRIEF.md
# Posted-Write Bridge Buffer

This block connects a fast upstream request port to a slower downstream port. A write from the upstream side arrives with its address, attributes and up to `MAXB` data beats in one request. The bridge stores every beat in a beat-wide queue, along with that beat's own address and a copy of the attributes. When posting is on, the requester is released as soon as the beats are queued, and the queue then empties to the downstream port one beat per handshake without the requester's help.

Reads are single-beat and always wait for their downstream reply. A read is held until every write queued before it has completed its downstream handshake. It is then issued, and its data is handed back together with the upstream acknowledge. When posting is off, a write still goes through the queue, but its acknowledge is held until the downstream side has taken its final beat. The posting control is sampled only when the bridge is idle and the queue is empty. A status output shows when the queue holds nothing.

Top module: `pwb_bridge`

## Requirements
- R1: While reset is asserted and after it is released, `up_ack` and `dn_valid` are 0 and `fifo_empty` is 1.
- R2: With posting on and the bridge idle, a write that fits in the queue gets `up_ack` in the same cycle as `up_valid`, before any of its beats appears downstream.
- R3: The queue holds at most `DEPTH` (8) beats in any mix of bursts and singles. A write of `up_len+1` beats is not acknowledged until that many entries are free, and it is never partly queued.
- R4: Queued beats leave downstream in arrival order. Beat k of a burst carries the request address plus k·(DW/8) bytes, data word k (`up_wdata[k*DW +: DW]`), the request's attributes and `dn_write`=1.
- R5: With posting off, a write's `up_ack` comes exactly one cycle after the downstream handshake of its last beat.
- R6: A read (`up_write`=0, `up_len` ignored) appears downstream (`dn_write`=0) only after every earlier write beat has completed its downstream handshake.
- R7: Read data is returned on `up_rdata` in the cycle that `up_ack` is 1. That cycle directly follows the downstream read handshake, and the data equals `dn_rdata` captured at that handshake.
- R8: `post_en` is sampled only while the bridge is idle with an empty queue, and the sampled value governs requests from the next cycle. Requests accepted before that keep the mode they were accepted under.
- R9: `fifo_empty` is 0 while any write beat is queued and 1 once all have been issued downstream.
- R10: While `dn_valid` is 1 and `dn_ack` is 0, the downstream address, write flag, attributes and data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | 1 = acknowledge writes on queueing, 0 = after downstream completion |
| up_valid | input | 1 | Upstream request present, held until `up_ack` |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Byte address of the first beat |
| up_attr | input | TW | Transfer attributes |
| up_len | input | LW | Write beats minus one |
| up_wdata | input | MAXB*DW | Write data, beat k in slice k |
| up_ack | output | 1 | Request completed this cycle |
| up_rdata | output | DW | Read data, valid with `up_ack` on a read |
| dn_valid | output | 1 | Downstream beat present |
| dn_write | output | 1 | 1 = write beat, 0 = read |
| dn_addr | output | AW | Downstream byte address |
| dn_attr | output | TW | Downstream attributes |
| dn_wdata | output | DW | Downstream write data |
| dn_ack | input | 1 | Downstream target accepts the beat |
| dn_rdata | input | DW | Downstream read data, valid with `dn_ack` on a read |
| fifo_empty | output | 1 | No write beat queued |

## Verification
The hardest case to reach is a write that must wait for queue space and must not be partly taken. To get there, the bench model of the downstream target grants handshakes only from a budget. With the budget at zero, two four-beat bursts fill the queue. A two-beat write then waits while the budget is raised one beat at a time, so the bench can see that the acknowledge stays low with one entry free and rises only when two are free. A second hard case is a mode change with beats still queued. It is reached by changing `post_en` while the budget holds beats in the queue.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WWAIT,
      ST_RDRAIN,
      ST_RISSUE,
      ST_RRESP
   } pwb_state_e;
endpackage

// File: rtl/pwb_burst_expand.sv
module pwb_burst_expand #(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int MAXB = 4,
   parameter int LW   = $clog2(MAXB),
   parameter int CW   = $clog2(MAXB + 1)
) (
   input  logic [AW-1:0]      base_addr,
   input  logic [LW-1:0]      len,
   output logic [MAXB*AW-1:0] beat_addr,
   output logic [CW-1:0]      beat_cnt
);
   localparam int STEP = DW / 8;

   assign beat_cnt = CW'(len) + CW'(1);

   for (genvar g = 0; g < MAXB; g++) begin : g_beat
      assign beat_addr[g*AW +: AW] = base_addr + AW'(g * STEP);
   end
endmodule

// File: rtl/pwb_beat_fifo.sv
module pwb_beat_fifo #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 4,
   parameter int MAXB  = 4,
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(MAXB + 1),
   parameter int PW    = $clog2(DEPTH),
   parameter int CNTW  = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     push_n,
   input  logic [MAXB*AW-1:0] push_addr,
   input  logic [TW-1:0]     push_attr,
   input  logic [MAXB*DW-1:0] push_data,
   input  logic              pop,
   output logic [AW-1:0]     head_addr,
   output logic [TW-1:0]     head_attr,
   output logic [DW-1:0]     head_data,
   output logic [CNTW-1:0]   count,
   output logic              empty
);
   logic [AW-1:0] mem_a [DEPTH];
   logic [TW-1:0] mem_t [DEPTH];
   logic [DW-1:0] mem_d [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      for (int i = 0; i < MAXB; i++) begin
         if (CW'(i) < push_n) begin
            mem_a[wr_q + PW'(i)] <= push_addr[i*AW +: AW];
            mem_t[wr_q + PW'(i)] <= push_attr;
            mem_d[wr_q + PW'(i)] <= push_data[i*DW +: DW];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         wr_q  <= wr_q + PW'(push_n);
         rd_q  <= rd_q + PW'(pop);
         cnt_q <= cnt_q + CNTW'(push_n) - CNTW'(pop);
      end
   end

   assign head_addr = mem_a[rd_q];
   assign head_attr = mem_t[rd_q];
   assign head_data = mem_d[rd_q];
   assign count     = cnt_q;
   assign empty     = (cnt_q == '0);

   // R3: queue never holds more than DEPTH beats, never pops when empty
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_n != '0) |-> (CNTW'(push_n) <= CNTW'(DEPTH) - cnt_q));
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));
endmodule

// File: rtl/pwb_up_ctrl.sv
module pwb_up_ctrl
   import pwb_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 4,
   parameter int MAXB  = 4,
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(MAXB),
   parameter int CNTW  = $clog2(DEPTH) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            post_en,
   input  logic            up_valid,
   input  logic            up_write,
   input  logic [AW-1:0]   up_addr,
   input  logic [TW-1:0]   up_attr,
   input  logic [LW-1:0]   up_len,
   input  logic [CNTW-1:0] fifo_count,
   input  logic            fifo_empty,
   input  logic            dn_ack,
   input  logic [DW-1:0]   dn_rdata,
   output logic            up_ack,
   output logic [DW-1:0]   up_rdata,
   output logic            push_en,
   output logic            rd_active,
   output logic [AW-1:0]   rd_addr,
   output logic [TW-1:0]   rd_attr
);
   pwb_state_e st_q, st_d;
   logic posted_q;
   logic [DW-1:0] rdata_q;
   logic [CNTW-1:0] free_n, need_n;
   logic room;

   assign free_n = CNTW'(DEPTH) - fifo_count;
   assign need_n = CNTW'(up_len) + CNTW'(1);
   assign room   = (need_n <= free_n);

   always_comb begin
      st_d    = st_q;
      push_en = 1'b0;
      up_ack  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (up_valid) begin
               if (!up_write) begin
                  st_d = ST_RDRAIN;
               end else if (posted_q) begin
                  if (room) begin
                     push_en = 1'b1;
                     up_ack  = 1'b1;
                  end
               end else if (fifo_empty) begin
                  push_en = 1'b1;
                  st_d    = ST_WWAIT;
               end
            end
         end
         ST_WWAIT: begin
            if (fifo_empty) begin
               up_ack = 1'b1;
               st_d   = ST_IDLE;
            end
         end
         ST_RDRAIN: if (fifo_empty) st_d = ST_RISSUE;
         ST_RISSUE: if (dn_ack) st_d = ST_RRESP;
         ST_RRESP: begin
            up_ack = 1'b1;
            st_d   = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         posted_q <= 1'b1;
         rdata_q  <= '0;
         rd_addr  <= '0;
         rd_attr  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && fifo_empty) posted_q <= post_en;
         if (st_q == ST_IDLE && up_valid && !up_write) begin
            rd_addr <= up_addr;
            rd_attr <= up_attr;
         end
         if (st_q == ST_RISSUE && dn_ack) rdata_q <= dn_rdata;
      end
   end

   assign rd_active = (st_q == ST_RISSUE);
   assign up_rdata  = rdata_q;

   // R8: the posting mode is frozen unless idle with an empty queue
   a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_q == ST_IDLE && fifo_empty) |=> $stable(posted_q));
   // R5: a write waiting on downstream completion is released only when the queue is drained
   a_r5_np_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WWAIT && !fifo_empty) |-> !up_ack);
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 4,
   parameter int MAXB  = 4,
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(MAXB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_en,
   input  logic              up_valid,
   input  logic              up_write,
   input  logic [AW-1:0]     up_addr,
   input  logic [TW-1:0]     up_attr,
   input  logic [LW-1:0]     up_len,
   input  logic [MAXB*DW-1:0] up_wdata,
   output logic              up_ack,
   output logic [DW-1:0]     up_rdata,
   output logic              dn_valid,
   output logic              dn_write,
   output logic [AW-1:0]     dn_addr,
   output logic [TW-1:0]     dn_attr,
   output logic [DW-1:0]     dn_wdata,
   input  logic              dn_ack,
   input  logic [DW-1:0]     dn_rdata,
   output logic              fifo_empty
);
   localparam int CW   = $clog2(MAXB + 1);
   localparam int CNTW = $clog2(DEPTH) + 1;

   if (DEPTH < MAXB) begin : g_bad_depth
      $error("DEPTH must hold one whole burst");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("DEPTH must be a power of two");
   end
   if (MAXB < 2 || (MAXB & (MAXB - 1)) != 0) begin : g_bad_maxb
      $error("MAXB must be a power of two of at least 2");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end

   logic [MAXB*AW-1:0] beat_addr;
   logic [CW-1:0]      beat_cnt, push_n;
   logic               push_en, rd_active, pop, q_empty;
   logic [AW-1:0]      head_addr, rd_addr;
   logic [TW-1:0]      head_attr, rd_attr;
   logic [DW-1:0]      head_data;
   logic [CNTW-1:0]    q_count;

   pwb_burst_expand #(.AW(AW), .DW(DW), .MAXB(MAXB), .LW(LW), .CW(CW)) u_expand (
      .base_addr (up_addr),
      .len       (up_len),
      .beat_addr (beat_addr),
      .beat_cnt  (beat_cnt)
   );

   assign push_n = push_en ? beat_cnt : '0;

   pwb_beat_fifo #(.AW(AW), .DW(DW), .TW(TW), .MAXB(MAXB), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    (push_n),
      .push_addr (beat_addr),
      .push_attr (up_attr),
      .push_data (up_wdata),
      .pop       (pop),
      .head_addr (head_addr),
      .head_attr (head_attr),
      .head_data (head_data),
      .count     (q_count),
      .empty     (q_empty)
   );

   pwb_up_ctrl #(.AW(AW), .DW(DW), .TW(TW), .MAXB(MAXB), .DEPTH(DEPTH), .LW(LW), .CNTW(CNTW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .post_en    (post_en),
      .up_valid   (up_valid),
      .up_write   (up_write),
      .up_addr    (up_addr),
      .up_attr    (up_attr),
      .up_len     (up_len),
      .fifo_count (q_count),
      .fifo_empty (q_empty),
      .dn_ack     (dn_ack),
      .dn_rdata   (dn_rdata),
      .up_ack     (up_ack),
      .up_rdata   (up_rdata),
      .push_en    (push_en),
      .rd_active  (rd_active),
      .rd_addr    (rd_addr),
      .rd_attr    (rd_attr)
   );

   assign dn_valid   = rd_active | !q_empty;
   assign dn_write   = !rd_active;
   assign dn_addr    = rd_active ? rd_addr : head_addr;
   assign dn_attr    = rd_active ? rd_attr : head_attr;
   assign dn_wdata   = rd_active ? '0 : head_data;
   assign pop        = !rd_active && !q_empty && dn_ack;
   assign fifo_empty = q_empty;

   // R10: an unaccepted downstream beat holds still
   a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)
                                 && $stable(dn_attr) && $stable(dn_wdata)));
   // R6: a read is only on the downstream port once all write beats have left
   a_r6_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_write) |-> fifo_empty);
   // R7: the upstream reply follows the downstream read handshake directly
   a_r7_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_write && dn_ack) |=> up_ack);
   // R1: nothing is offered downstream in the first cycle after reset
   a_r1_quiet_reset: assert property (@(posedge clk)
      !rst_n |=> !dn_valid);
endmodule

// File: tb/pwb_bridge_test.sv
module pwb_bridge_test;
   localparam int AW = 32, DW = 32, TW = 4, MAXB = 4, DEPTH = 8, LW = 2;

   logic clk = 0, rst_n = 0, post_en = 1;
   logic up_valid = 0, up_write = 0;
   logic [AW-1:0] up_addr = '0;
   logic [TW-1:0] up_attr = '0;
   logic [LW-1:0] up_len = '0;
   logic [MAXB*DW-1:0] up_wdata = '0;
   logic up_ack, dn_valid, dn_write, fifo_empty;
   logic [DW-1:0] up_rdata, dn_wdata;
   logic [AW-1:0] dn_addr;
   logic [TW-1:0] dn_attr;
   logic dn_ack = 0;
   logic [DW-1:0] dn_rdata = '0;

   pwb_bridge uut (.*);

   always #10 clk = ~clk;

   int cyc = 0, n_chk = 0, n_fail = 0;
   int tgt_budget = 1000000, tgt_wait = 0, hold_viol = 0;
   int log_n = 0;
   logic [AW-1:0] log_addr [64];
   logic [DW-1:0] log_data [64];
   logic [TW-1:0] log_attr [64];
   logic          log_wr   [64];
   int            log_cyc  [64];

   initial forever begin @(posedge clk); cyc++; end

   function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
      return a ^ 32'hC0DE_0000;
   endfunction

   // downstream target model
   initial begin
      int w = 0;
      logic pv = 0, pa = 0;
      logic [AW-1:0] paddr = '0;
      logic [DW-1:0] pdata = '0;
      forever begin
         @(negedge clk);
         if (dn_valid && pv && !pa && (dn_addr != paddr || dn_wdata != pdata)) hold_viol++;
         pv = dn_valid; paddr = dn_addr; pdata = dn_wdata;
         if (dn_valid && tgt_budget > 0 && w >= tgt_wait) begin
            dn_ack = 1;
            dn_rdata = rd_fn(dn_addr);
            log_addr[log_n] = dn_addr; log_data[log_n] = dn_wdata;
            log_attr[log_n] = dn_attr; log_wr[log_n] = dn_write;
            log_cyc[log_n] = cyc;
            if (log_n < 63) log_n++;
            tgt_budget--;
            w = 0;
         end else begin
            dn_ack = 0;
            if (dn_valid) w++; else w = 0;
         end
         pa = dn_ack;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [TW-1:0] t, input int len,
                           input logic [DW-1:0] base, output int lat, output int ack_cyc);
      int c0;
      @(posedge clk); #1;
      up_valid = 1; up_write = 1; up_addr = a; up_attr = t; up_len = LW'(len);
      for (int k = 0; k < MAXB; k++) up_wdata[k*DW +: DW] = base + DW'(k);
      c0 = cyc;
      forever begin @(negedge clk); if (up_ack) break; end
      ack_cyc = cyc; lat = cyc - c0;
      @(posedge clk); #1; up_valid = 0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int ack_cyc);
      @(posedge clk); #1;
      up_valid = 1; up_write = 0; up_addr = a; up_attr = 4'h9; up_len = '0;
      forever begin @(negedge clk); if (up_ack) break; end
      d = up_rdata; ack_cyc = cyc;
      @(posedge clk); #1; up_valid = 0;
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (fifo_empty && !dn_valid) break;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(up_ack == 0 && dn_valid == 0 && fifo_empty == 1, "R1 reset outputs",
          {up_ack, dn_valid, fifo_empty}, 3'b001);
   endtask

   task automatic t_posted_single();
      int lat, ac, n0;
      tgt_budget = 0; tgt_wait = 0; n0 = log_n;
      do_write(32'h100, 4'h3, 0, 32'h11, lat, ac);
      chk(lat == 0, "R2 same-cycle ack", lat, 0);
      @(negedge clk);
      chk(log_n == n0, "R2 nothing downstream yet", log_n, n0);
      chk(fifo_empty == 0, "R9 not empty with queued beat", fifo_empty, 0);
      tgt_budget = 1000000;
      wait_drain();
      chk(fifo_empty == 1, "R9 empty after drain", fifo_empty, 1);
      chk(log_addr[n0] == 32'h100 && log_data[n0] == 32'h11 && log_attr[n0] == 4'h3 && log_wr[n0],
          "R4 single beat fields", log_data[n0], 32'h11);
   endtask

   task automatic t_burst_order();
      int lat, ac, n0;
      tgt_wait = 1; n0 = log_n;
      do_write(32'h200, 4'h5, 3, 32'hA0, lat, ac);
      do_write(32'h300, 4'h6, 1, 32'hB0, lat, ac);
      wait_drain();
      chk(log_n == n0 + 6, "R4 beat count", log_n - n0, 6);
      for (int k = 0; k < 4; k++)
         chk(log_addr[n0+k] == 32'h200 + 4*k && log_data[n0+k] == 32'hA0 + k && log_attr[n0+k] == 4'h5,
             "R4 first burst beat", log_addr[n0+k], 32'h200 + 4*k);
      for (int k = 0; k < 2; k++)
         chk(log_addr[n0+4+k] == 32'h300 + 4*k && log_data[n0+4+k] == 32'hB0 + k && log_attr[n0+4+k] == 4'h6,
             "R4 second burst beat", log_addr[n0+4+k], 32'h300 + 4*k);
   endtask

   task automatic t_full();
      int lat, ac, n0, lat3, ac3;
      bit done3 = 0;
      tgt_budget = 0; tgt_wait = 0; n0 = log_n;
      do_write(32'h1000, 4'h1, 3, 32'h10, lat, ac);
      chk(lat == 0, "R3 first burst accepted", lat, 0);
      do_write(32'h2000, 4'h2, 3, 32'h20, lat, ac);
      chk(lat == 0, "R3 fills to eight beats", lat, 0);
      fork
         begin do_write(32'h3000, 4'h3, 1, 32'h30, lat3, ac3); done3 = 1; end
         begin
            repeat (8) @(negedge clk);
            chk(done3 == 0, "R3 withheld when full", done3, 0);
            tgt_budget = 1;
            repeat (6) @(negedge clk);
            chk(done3 == 0 && log_n == n0 + 1, "R3 withheld with one free", done3, 0);
            tgt_budget = 1;
         end
      join
      chk(log_n == n0 + 2, "R3 acked once two free", log_n - n0, 2);
      tgt_budget = 1000000;
      wait_drain();
      chk(log_n == n0 + 10, "R3 all beats delivered", log_n - n0, 10);
      chk(log_addr[n0+8] == 32'h3000 && log_addr[n0+9] == 32'h3004 && log_data[n0+9] == 32'h31,
          "R3 whole burst kept together", log_addr[n0+9], 32'h3004);
      chk(log_addr[n0+7] == 32'h200C, "R4 order across bursts", log_addr[n0+7], 32'h200C);
   endtask

   task automatic t_nonposted();
      int lat, ac, n0;
      post_en = 0; repeat (3) @(posedge clk);
      tgt_wait = 3; n0 = log_n;
      do_write(32'h400, 4'h7, 1, 32'h40, lat, ac);
      chk(log_n == n0 + 2, "R5 beats done before ack", log_n - n0, 2);
      chk(ac == log_cyc[n0+1] + 1, "R5 ack one cycle after last beat", ac, log_cyc[n0+1] + 1);
      post_en = 1; repeat (3) @(posedge clk);
   endtask

   task automatic t_read();
      int lat, ac, n0;
      logic [DW-1:0] d;
      tgt_wait = 2; n0 = log_n;
      do_write(32'h500, 4'h4, 3, 32'h50, lat, ac);
      chk(lat == 0, "R2 posted burst before read", lat, 0);
      do_read(32'h800, d, ac);
      chk(log_n == n0 + 5 && !log_wr[n0+4] && log_wr[n0+3], "R6 read after all writes",
          log_n - n0, 5);
      chk(log_addr[n0+4] == 32'h800, "R6 read address", log_addr[n0+4], 32'h800);
      chk(d == rd_fn(32'h800), "R7 read data", d, rd_fn(32'h800));
      chk(ac == log_cyc[n0+4] + 1, "R7 ack follows downstream read", ac, log_cyc[n0+4] + 1);
   endtask

   task automatic t_mode();
      int lat, ac, n0;
      tgt_budget = 0; tgt_wait = 0;
      do_write(32'h600, 4'h2, 0, 32'h60, lat, ac);
      @(posedge clk); #1; post_en = 0;
      repeat (3) @(posedge clk);
      do_write(32'h700, 4'h2, 0, 32'h70, lat, ac);
      chk(lat == 0, "R8 mode held while beats queued", lat, 0);
      tgt_budget = 1000000;
      wait_drain();
      repeat (3) @(posedge clk);
      tgt_wait = 2; n0 = log_n;
      do_write(32'h900, 4'h2, 0, 32'h90, lat, ac);
      chk(lat >= 3 && log_n == n0 + 1, "R8 new mode after drain", lat, 3);
      post_en = 1; repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(posedge clk); #1; rst_n = 1;
      repeat (2) @(posedge clk);
      t_posted_single();
      t_burst_order();
      t_full();
      t_nonposted();
      t_read();
      t_mode();
      wait_drain();
      chk(hold_viol == 0, "R10 downstream beat held until accepted", hold_viol, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule